// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block holds the register state of one 32-pin general-purpose I/O bank: the output value, a per-pin direction and a per-pin output enable. It also returns the current pin levels. Software updates output bits through two write-only half-word ports. Each port carries a 16-bit keep-mask in its upper half and 16 data bits in its lower half. Any subset of output bits can therefore change in a single bus write, with no read-modify-write sequence, and another agent cannot interleave a conflicting update on other bits.

The bank sits on a simple single-cycle register bus. A write is taken on the clock edge where the write enable is high. A read launched with the read enable returns its data one cycle later. Pin levels pass through a two-flop synchroniser before software can read them. The `BANK_IDX` parameter places the bank's registers at that bank's position in a shared address map: the mask ports move in steps of 8 bytes, the pin-level register in steps of 4, and the direction and enable registers in steps of 0x40.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset the output value, direction and output enable are all zero. `pinOut` and `pinOe` are zero, and reads of the direction and enable registers return zero.
- R2: A write to the lower mask port (offset 0x000 + 8·BANK_IDX) acts on `pinOut[15:0]`. Write bit 16+n = 1 keeps output bit n. Write bit 16+n = 0 loads output bit n from write bit n. The change is visible from the edge that takes the write.
- R3: A write to the upper mask port (offset 0x004 + 8·BANK_IDX) acts the same way on `pinOut[31:16]`. Write bit 16+n masks output bit 16+n, and write bit n is its data. `pinOut[15:0]` does not change.
- R4: The direction register (0x204 + 0x40·BANK_IDX, 1 = output) and the enable register (0x208 + 0x40·BANK_IDX) are full 32-bit read/write registers. `pinOe[n]` is high only when both bit n of direction and bit n of enable are 1.
- R5: A read of the pin register (0x060 + 4·BANK_IDX) returns the pins with bit n equal to `pinIn[n]`, after a two-flop synchroniser. A read launched in the same cycle that a pin changes returns the old level. A read launched three cycles later returns the new level.
- R6: Read data appears on `busRdData` in the cycle after the one in which `busRdEn` was high. `busRdData` is zero in every cycle that does not follow a read.
- R7: Reads of either mask port, and reads of any unmapped address, return zero. Writes to the pin register or to unmapped addresses, including another bank's mask ports, change no output or register.
- R8: `pinOut` reflects the output value register whatever the direction and enable settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | 12 | Byte address of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after the read strobe |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Output value per pin |
| pinOe | output | 32 | Drive enable per pin |

## Verification
On every cycle, the assertions check the mask merge of the lower port: masked bits hold and unmasked bits take the data. They also check that an upper-port write leaves the lower half alone, that the direction register moves only on its own strobe, and that reads of the mask ports or of unmapped addresses return zero. Only the bench's scenarios can show the rest. That covers the exact address of each register for the bank position, the synchroniser's latency as seen through a read, the combination of direction and enable into `pinOe`, and the cases where writes to other banks' ports or to the pin register are dropped.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_PINS = 2'd1,
    RD_DIR  = 2'd2,
    RD_OE   = 2'd3
  } rdSel_e;

  // strobes handed from the address decoder to the datapath
  typedef struct packed {
    logic [1:0] wrHalf;  // bit 0: lower mask port, bit 1: upper mask port
    logic       wrDir;
    logic       wrOe;
    logic       rdEn;
    rdSel_e     rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK_IDX = 0
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] OFS_LO   = ADDR_W'(8 * BANK_IDX);
  localparam logic [ADDR_W-1:0] OFS_HI   = ADDR_W'(8 * BANK_IDX + 4);
  localparam logic [ADDR_W-1:0] OFS_PINS = ADDR_W'(32'h060 + 4 * BANK_IDX);
  localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(32'h204 + 32'h40 * BANK_IDX);
  localparam logic [ADDR_W-1:0] OFS_OE   = ADDR_W'(32'h208 + 32'h40 * BANK_IDX);

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_ZERO;
    if (wrEn) begin
      strb.wrHalf[0] = (addr == OFS_LO);
      strb.wrHalf[1] = (addr == OFS_HI);
      strb.wrDir     = (addr == OFS_DIR);
      strb.wrOe      = (addr == OFS_OE);
    end
    if (rdEn) begin
      strb.rdEn = 1'b1;
      if (addr == OFS_PINS)     strb.rdSel = RD_PINS;
      else if (addr == OFS_DIR) strb.rdSel = RD_DIR;
      else if (addr == OFS_OE)  strb.rdSel = RD_OE;
      else                      strb.rdSel = RD_ZERO;
    end
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] outData,
  output logic [PIN_W-1:0] dirReg,
  output logic [PIN_W-1:0] oeReg,
  output logic [PIN_W-1:0] rdData
);

  localparam int HALF   = PIN_W / 2;
  localparam int NHALVES = 2;

  logic [HALF-1:0]  wrMask;
  logic [HALF-1:0]  wrBits;
  logic [PIN_W-1:0] pinMeta;
  logic [PIN_W-1:0] pinSync;
  logic [PIN_W-1:0] rdNext;

  assign wrMask = wrData[PIN_W-1:HALF];
  assign wrBits = wrData[HALF-1:0];

  // one merge register per half-word port
  for (genvar h = 0; h < NHALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        outData[h*HALF +: HALF] <= '0;
      end else if (strb.wrHalf[h]) begin
        outData[h*HALF +: HALF] <= (outData[h*HALF +: HALF] & wrMask) |
                                   (wrBits & ~wrMask);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirReg <= '0;
      oeReg  <= '0;
    end else begin
      if (strb.wrDir) dirReg <= wrData;
      if (strb.wrOe)  oeReg  <= wrData;
    end
  end

  // two-flop synchroniser for the pin levels
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinMeta <= '0;
      pinSync <= '0;
    end else begin
      pinMeta <= pinIn;
      pinSync <= pinMeta;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_PINS: rdNext = pinSync;
      RD_DIR:  rdNext = dirReg;
      RD_OE:   rdNext = oeReg;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
    else                rdData <= '0;
  end

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrHalf[0] |=> ((outData[HALF-1:0] ^ $past(outData[HALF-1:0])) &
                        $past(wrData[PIN_W-1:HALF])) == '0);

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrHalf[0] |=> ((outData[HALF-1:0] ^ $past(wrData[HALF-1:0])) &
                        ~$past(wrData[PIN_W-1:HALF])) == '0);

  // R3
  upper_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrHalf[1] |=> $stable(outData[HALF-1:0]));

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrDir |=> $stable(dirReg));

  // R7
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdEn && strb.rdSel == RD_ZERO) |=> rdData == '0);

  // R6
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdEn |=> rdData == '0);

endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PIN_W    = 32,
  parameter int BANK_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PIN_W-1:0]  busWrData,
  output logic [PIN_W-1:0]  busRdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);

  strobe_t          strb;
  logic [PIN_W-1:0] dirReg;
  logic [PIN_W-1:0] oeReg;

  gpio_bank_ctrl #(
    .ADDR_W   (ADDR_W),
    .BANK_IDX (BANK_IDX)
  ) u_ctrl (
    .wrEn (busWrEn),
    .rdEn (busRdEn),
    .addr (busAddr),
    .strb (strb)
  );

  gpio_bank_dp #(
    .PIN_W (PIN_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrData  (busWrData),
    .pinIn   (pinIn),
    .outData (pinOut),
    .dirReg  (dirReg),
    .oeReg   (oeReg),
    .rdData  (busRdData)
  );

  assign pinOe = dirReg & oeReg;

endmodule

// File: tb/gpio_mask_bank_tb.sv
module gpio_mask_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gpio_mask_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe)
  );

  // {upper port?, {mask,data} word, expected pinOut afterwards}
  localparam logic [64:0] VEC [8] = '{
    {1'b0, 32'h0000_A5A5, 32'h0000_A5A5},
    {1'b1, 32'h0000_1234, 32'h1234_A5A5},
    {1'b0, 32'hFFFE_0000, 32'h1234_A5A4},
    {1'b0, 32'hFFFF_FFFF, 32'h1234_A5A4},
    {1'b1, 32'h7FFF_8000, 32'h9234_A5A4},
    {1'b1, 32'h00FF_0000, 32'h0034_A5A4},
    {1'b0, 32'hF0F0_0F0F, 32'h0034_AFAF},
    {1'b1, 32'hFF00_FFFF, 32'h00FF_AFAF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOut", pinOut, 32'h0);
    check("R1 pinOe", pinOe, 32'h0);
    busRead(12'h204, rd); check("R1 dir", rd, 32'h0);
    busRead(12'h208, rd); check("R1 oe", rd, 32'h0);

    // R2 R3 R8 vector table, direction still all inputs
    foreach (VEC[i]) begin
      busWrite(VEC[i][64] ? 12'h004 : 12'h000, VEC[i][63:32]);
      check(VEC[i][64] ? "R3 upper merge" : "R2 lower merge", pinOut, VEC[i][31:0]);
    end
    check("R8 pinOe with dir clear", pinOe, 32'h0);

    // R6 idle read data
    @(negedge clk);
    check("R6 idle rdData", busRdData, 32'h0);

    // R4 direction and enable
    busWrite(12'h204, 32'h0000_FFFF);
    check("R4 pinOe dir only", pinOe, 32'h0);
    busWrite(12'h208, 32'h00FF_00FF);
    check("R4 pinOe", pinOe, 32'h0000_00FF);
    busRead(12'h204, rd); check("R4 dir read", rd, 32'h0000_FFFF);
    busRead(12'h208, rd); check("R4 oe read", rd, 32'h00FF_00FF);
    check("R8 pinOut unchanged", pinOut, 32'h00FF_AFAF);

    // R7 zero reads and ignored writes
    busRead(12'h000, rd); check("R7 lower port read", rd, 32'h0);
    busRead(12'h004, rd); check("R7 upper port read", rd, 32'h0);
    busRead(12'h100, rd); check("R7 unmapped read", rd, 32'h0);
    busWrite(12'h060, 32'hFFFF_FFFF);
    busWrite(12'h008, 32'h0000_FFFF);
    busWrite(12'h244, 32'hFFFF_FFFF);
    check("R7 pinOut after ignored writes", pinOut, 32'h00FF_AFAF);
    busRead(12'h204, rd); check("R7 dir after ignored writes", rd, 32'h0000_FFFF);
    check("R7 pinOe after ignored writes", pinOe, 32'h0000_00FF);

    // R5 synchroniser latency
    pinIn = 32'h1111_2222;
    repeat (4) @(negedge clk);
    busRead(12'h060, rd); check("R5 pins settled", rd, 32'h1111_2222);
    @(negedge clk);
    pinIn = 32'hDEAD_BEEF;
    busRdEn = 1'b1; busAddr = 12'h060;
    @(negedge clk);
    rd = busRdData; busRdEn = 1'b0;
    check("R5 same-cycle read old", rd, 32'h1111_2222);
    @(negedge clk);
    busRead(12'h060, rd); check("R5 later read new", rd, 32'hDEAD_BEEF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule